// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns the page-number part of a logical address into a physical page frame. It reads a translation tree held in memory. A walk request carries the virtual page number, the privilege mode and a flag for instruction fetch versus data access. The walker picks the supervisor or the user root pointer and reads one descriptor at each of three levels: root, pointer and page. Each read goes through a memory read port that allows only one outstanding request.

A page-level descriptor may be indirect. In that case the walker makes one more read at the location the descriptor names and treats the word it gets back as the real page descriptor. The walk ends in one of two ways: a translation for the translation cache, or a fault tagged with the level where the walk stopped. The result stays on the outputs until the consumer acknowledges it.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a walk is in progress, requests are not accepted.
- R2: The root table base comes from `srp` when `req_super` is 1 and from `urp` when it is 0. The value of `req_ifetch` does not change which tree is read or what the result is.
- R3: The virtual page number splits, from the top down, into a 7-bit root index, a 7-bit pointer index and a 6-bit page index. Each entry address is the table base plus the index times 4.
- R4: At root and pointer level, descriptor bits [1:0] equal to 10 or 11 mean resident. The next table base is the descriptor with bits [1:0] cleared. A value of 00 or 01 at these levels is invalid and ends the walk with a fault.
- R5: At page level, a resident descriptor (bits [1:0] = 10 or 11) gives the frame number in bits [31:12], and `res_fault` is 0. A value of 00 is invalid and faults with code 2.
- R6: At page level, bits [1:0] = 01 mean indirect. The walker makes one more read at the descriptor with bits [1:0] cleared. If that word is resident, it supplies the frame. If it is 00 or 01, the walk faults with code 3.
- R7: When `mem_err` is high with `mem_valid`, the walk ends at once with a fault whose code is the level of that read.
- R8: The fault codes are 0 for root, 1 for pointer, 2 for page and 3 for the indirect read. A walk makes exactly one memory read per level it reaches, and no read after the one that ends it.
- R9: `mem_req` is a single-cycle pulse. No new pulse is issued until `mem_valid` returns for the previous read.
- R10: Once `res_valid` is high, all result outputs hold steady until `res_ack`. After the acknowledge, the walker is idle on the next cycle.
- R11: The result echoes the page number, `req_super` and `req_ifetch` of the request that was accepted.
- R12: `res_valid` rises only on the cycle after a memory response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpage | input | 20 | Virtual page number (logical address bits 31:12) |
| req_super | input | 1 | 1 for a supervisor-mode access, 0 for user mode |
| req_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| urp | input | 32 | User root table base |
| srp | input | 32 | Supervisor root table base |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | 32 | Byte address of the descriptor being read |
| mem_valid | input | 1 | Read response present |
| mem_rdata | input | 32 | Descriptor word returned |
| mem_err | input | 1 | Read response is a bus error |
| res_valid | output | 1 | Result present |
| res_ack | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_lvl | output | 2 | Level where the walk stopped (0 root, 1 pointer, 2 page, 3 indirect) |
| res_frame | output | 20 | Physical frame number on success |
| res_vpage | output | 20 | Echo of the walked page number |
| res_super | output | 1 | Echo of the privilege mode |
| res_ifetch | output | 1 | Echo of the access type |

## Verification
Some properties are checked on every cycle. These are the handshake rules: the request pulse shape, the result holding steady until acknowledged, the return to idle after an acknowledge, `req_ready` never high together with a result, and a result appearing only after a memory response. Other behaviour can only be shown by the bench's scenarios, because it depends on the tree in memory. That covers descriptor decoding at each level, the choice of root pointer, following an indirect descriptor, the rejection of a second indirection, and how many reads each walk makes before it stops.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Walk level; the numeric value doubles as the fault code.
    typedef enum logic [1:0] {
        LVL_ROOT = 2'd0,
        LVL_PTR  = 2'd1,
        LVL_PAGE = 2'd2,
        LVL_IND  = 2'd3
    } walk_level_e;

    typedef enum logic [1:0] {
        DK_INVALID  = 2'd0,
        DK_INDIRECT = 2'd1,
        DK_RESIDENT = 2'd2
    } desc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    localparam int ENTRY_SHIFT = 2;

    function automatic desc_kind_e raw_kind(input logic [1:0] tbits);
        case (tbits)
            2'b00:   return DK_INVALID;
            2'b01:   return DK_INDIRECT;
            default: return DK_RESIDENT;
        endcase
    endfunction

    // Indirection is only meaningful on the first page-level read.
    function automatic desc_kind_e kind_at(input logic [1:0] tbits, input walk_level_e lvl);
        desc_kind_e k;
        k = raw_kind(tbits);
        if (k == DK_INDIRECT && lvl != LVL_PAGE) return DK_INVALID;
        return k;
    endfunction

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PAGE_IDX_W = 6
) (
    input  walk_level_e                                  lvl,
    input  logic [ADDR_W-1:0]                            base,
    input  logic [ROOT_IDX_W+PTR_IDX_W+PAGE_IDX_W-1:0]   vpn,
    output logic [ADDR_W-1:0]                            entry_addr
);
    localparam int PTR_LSB  = PAGE_IDX_W;
    localparam int ROOT_LSB = PAGE_IDX_W + PTR_IDX_W;

    logic [ADDR_W-1:0] idx;

    always_comb begin
        case (lvl)
            LVL_ROOT: idx = ADDR_W'(vpn[ROOT_LSB +: ROOT_IDX_W]);
            LVL_PTR:  idx = ADDR_W'(vpn[PTR_LSB +: PTR_IDX_W]);
            LVL_PAGE: idx = ADDR_W'(vpn[0 +: PAGE_IDX_W]);
            default:  idx = '0;   // indirect read: the pointer is the address
        endcase
        entry_addr = base + (idx << ENTRY_SHIFT);
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 12
) (
    input  logic [ADDR_W-1:0]          desc,
    input  walk_level_e                lvl,
    output desc_kind_e                 kind,
    output logic [ADDR_W-1:0]          next_base,
    output logic [ADDR_W-OFFSET_W-1:0] frame
);
    always_comb begin
        kind      = kind_at(desc[1:0], lvl);
        next_base = {desc[ADDR_W-1:2], 2'b00};
        frame     = desc[ADDR_W-1:OFFSET_W];
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PAGE_IDX_W = 6,
    localparam int VPN_W     = ROOT_IDX_W + PTR_IDX_W + PAGE_IDX_W,
    localparam int OFFSET_W  = ADDR_W - VPN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpage,
    input  logic              req_super,
    input  logic              req_ifetch,
    input  logic [ADDR_W-1:0] urp,
    input  logic [ADDR_W-1:0] srp,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              res_valid,
    input  logic              res_ack,
    output logic              res_fault,
    output logic [1:0]        res_fault_lvl,
    output logic [VPN_W-1:0]  res_frame,
    output logic [VPN_W-1:0]  res_vpage,
    output logic              res_super,
    output logic              res_ifetch
);
    walk_state_e       state_q;
    walk_level_e       lvl_q;
    logic [ADDR_W-1:0] base_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [VPN_W-1:0]  frame_q;
    logic              super_q, ifetch_q, fault_q;

    desc_kind_e        kind;
    logic [ADDR_W-1:0] next_base;
    logic [VPN_W-1:0]  frame_d;

    ptw_entry_addr #(
        .ADDR_W(ADDR_W), .ROOT_IDX_W(ROOT_IDX_W),
        .PTR_IDX_W(PTR_IDX_W), .PAGE_IDX_W(PAGE_IDX_W)
    ) addr_i (
        .lvl(lvl_q), .base(base_q), .vpn(vpn_q), .entry_addr(mem_addr)
    );

    ptw_desc_decode #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) dec_i (
        .desc(mem_rdata), .lvl(lvl_q), .kind(kind),
        .next_base(next_base), .frame(frame_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            lvl_q    <= LVL_ROOT;
            base_q   <= '0;
            vpn_q    <= '0;
            frame_q  <= '0;
            super_q  <= 1'b0;
            ifetch_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    base_q   <= (req_super ? srp : urp) & ~ADDR_W'(3);
                    vpn_q    <= req_vpage;
                    super_q  <= req_super;
                    ifetch_q <= req_ifetch;
                    lvl_q    <= LVL_ROOT;
                    fault_q  <= 1'b0;
                    state_q  <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (mem_valid) begin
                    if (mem_err || kind == DK_INVALID) begin
                        fault_q <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (kind == DK_INDIRECT) begin
                        base_q  <= next_base;
                        lvl_q   <= LVL_IND;
                        state_q <= ST_ISSUE;
                    end else if (lvl_q == LVL_ROOT || lvl_q == LVL_PTR) begin
                        base_q  <= next_base;
                        lvl_q   <= walk_level_e'(lvl_q + 2'd1);
                        state_q <= ST_ISSUE;
                    end else begin
                        frame_q <= frame_d;
                        state_q <= ST_DONE;
                    end
                end
                default: if (res_ack) state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req       = (state_q == ST_ISSUE);
        res_valid     = (state_q == ST_DONE);
        res_fault     = fault_q;
        res_fault_lvl = lvl_q;
        res_frame     = frame_q;
        res_vpage     = vpn_q;
        res_super     = super_q;
        res_ifetch    = ifetch_q;
    end

    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ack |=> res_valid && $stable(res_frame) && $stable(res_fault)
            && $stable(res_fault_lvl) && $stable(res_vpage));

    // R10
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ack |=> req_ready);

    // R1
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !res_valid && !mem_req);

    // R12
    res_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(mem_valid));

endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_super, req_ifetch;
    logic [19:0] req_vpage;
    logic [31:0] urp, srp;
    logic        mem_req, mem_valid, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic        res_valid, res_ack, res_fault, res_super, res_ifetch;
    logic [1:0]  res_fault_lvl;
    logic [19:0] res_frame, res_vpage;

    int checks = 0;
    int fails  = 0;
    int reads  = 0;
    int cycles = 0;
    int lat    = 0;

    always #10 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpage(req_vpage), .req_super(req_super), .req_ifetch(req_ifetch),
        .urp(urp), .srp(srp), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .res_valid(res_valid), .res_ack(res_ack), .res_fault(res_fault),
        .res_fault_lvl(res_fault_lvl), .res_frame(res_frame),
        .res_vpage(res_vpage), .res_super(res_super), .res_ifetch(res_ifetch)
    );

    // Memory model: 2048 words, configurable latency, a few error addresses.
    logic [31:0] mem [2048];
    logic        pend;
    int          cnt;
    logic [31:0] paddr;

    function automatic logic is_err(input logic [31:0] a);
        return a == 32'h014 || a == 32'h40C || a == 32'h81C || a == 32'hC0C;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_valid <= 1'b0;
        if (rst) begin
            pend <= 1'b0;
        end else begin
            if (pend) begin
                if (cnt == 0) begin
                    mem_valid <= 1'b1;
                    mem_err   <= is_err(paddr);
                    mem_rdata <= is_err(paddr) ? 32'hFFFF_FFFF : mem[paddr[12:2]];
                    pend      <= 1'b0;
                end else begin
                    cnt <= cnt - 1;
                end
            end
            if (mem_req) begin
                pend  <= 1'b1;
                cnt   <= lat;
                paddr <= mem_addr;
                reads <= reads + 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] v);
        mem[a[12:2]] = v;
    endtask

    typedef struct packed {
        logic        sup;
        logic        ifetch;
        logic [6:0]  r;
        logic [6:0]  p;
        logic [5:0]  g;
        logic        flt;
        logic [1:0]  code;
        logic [19:0] frame;
        logic [2:0]  nrd;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd0, 1'b0, 2'd0, 20'h12345, 3'd3}, // R4 R5 resident type 10
        '{1'b0, 1'b1, 7'd1, 7'd0, 6'd1, 1'b0, 2'd0, 20'h0ABCD, 3'd3}, // R5 type 11
        '{1'b0, 1'b0, 7'd4, 7'd0, 6'd0, 1'b0, 2'd0, 20'h12345, 3'd3}, // R4 root type 11
        '{1'b1, 1'b0, 7'd1, 7'd0, 6'd0, 1'b0, 2'd0, 20'h77777, 3'd3}, // R2 supervisor tree
        '{1'b0, 1'b0, 7'd2, 7'd0, 6'd0, 1'b1, 2'd0, 20'h0,     3'd1}, // R4 root invalid
        '{1'b0, 1'b1, 7'd3, 7'd0, 6'd0, 1'b1, 2'd0, 20'h0,     3'd1}, // R4 root type 01
        '{1'b0, 1'b0, 7'd1, 7'd1, 6'd0, 1'b1, 2'd1, 20'h0,     3'd2}, // R4 pointer invalid
        '{1'b0, 1'b0, 7'd1, 7'd2, 6'd0, 1'b1, 2'd1, 20'h0,     3'd2}, // R4 pointer type 01
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd2, 1'b1, 2'd2, 20'h0,     3'd3}, // R5 page invalid
        '{1'b0, 1'b1, 7'd1, 7'd0, 6'd3, 1'b0, 2'd0, 20'h55555, 3'd4}, // R6 indirect ok
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd4, 1'b1, 2'd3, 20'h0,     3'd4}, // R6 indirect to invalid
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd5, 1'b1, 2'd3, 20'h0,     3'd4}, // R6 double indirect
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd6, 1'b1, 2'd3, 20'h0,     3'd4}, // R7 error on indirect read
        '{1'b0, 1'b0, 7'd1, 7'd0, 6'd7, 1'b1, 2'd2, 20'h0,     3'd3}, // R7 error on page read
        '{1'b0, 1'b0, 7'd5, 7'd0, 6'd0, 1'b1, 2'd0, 20'h0,     3'd1}, // R7 error on root read
        '{1'b0, 1'b0, 7'd1, 7'd3, 6'd0, 1'b1, 2'd1, 20'h0,     3'd2}, // R7 error on pointer read
        '{1'b1, 1'b1, 7'd2, 7'd0, 6'd0, 1'b1, 2'd0, 20'h0,     3'd1}, // R2 supervisor root invalid
        '{1'b0, 1'b1, 7'd1, 7'd0, 6'd0, 1'b0, 2'd0, 20'h12345, 3'd3}  // R2 ifetch has no effect
    };

    task automatic wait_result();
        for (int t = 0; t < 200 && !res_valid; t++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        reads      = 0;
        req_valid  = 1'b1;
        req_vpage  = {v.r, v.p, v.g};
        req_super  = v.sup;
        req_ifetch = v.ifetch;
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        check(res_valid === 1'b1, $sformatf("R1 vec%0d result appears", idx), 32'(res_valid), 32'd1);
        check(res_fault === v.flt, $sformatf("R8 vec%0d fault flag", idx), 32'(res_fault), 32'(v.flt));
        if (v.flt)
            check(res_fault_lvl === v.code, $sformatf("R8 vec%0d fault code", idx), 32'(res_fault_lvl), 32'(v.code));
        else
            check(res_frame === v.frame, $sformatf("R5 vec%0d frame", idx), 32'(res_frame), 32'(v.frame));
        check(reads == int'(v.nrd), $sformatf("R8 vec%0d read count", idx), 32'(reads), 32'(v.nrd));
        check(res_vpage === {v.r, v.p, v.g} && res_super === v.sup && res_ifetch === v.ifetch,
              $sformatf("R11 vec%0d echo", idx), 32'(res_vpage), 32'({v.r, v.p, v.g}));
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        check(req_ready === 1'b1, $sformatf("R10 vec%0d idle after ack", idx), 32'(req_ready), 32'd1);
    endtask

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        // user root at 0x000, supervisor root at 0x200
        put(32'h004, 32'h0000_0402);
        put(32'h00C, 32'h0000_0401);
        put(32'h010, 32'h0000_0403);
        put(32'h204, 32'h0000_0602);
        // pointer tables
        put(32'h400, 32'h0000_0802);
        put(32'h408, 32'h0000_0801);
        put(32'h600, 32'h0000_0A02);
        // page tables
        put(32'h800, 32'h1234_5002);
        put(32'h804, 32'h0ABC_D003);
        put(32'h80C, 32'h0000_0C01);
        put(32'h810, 32'h0000_0C05);
        put(32'h814, 32'h0000_0C09);
        put(32'h818, 32'h0000_0C0D);
        put(32'hA00, 32'h7777_7002);
        // indirect targets
        put(32'hC00, 32'h5555_5002);
        put(32'hC08, 32'h0000_0C01);

        rst = 1'b1; req_valid = 1'b0; req_vpage = '0; req_super = 1'b0;
        req_ifetch = 1'b0; res_ack = 1'b0; urp = 32'h0; srp = 32'h200;
        mem_err = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(res_valid === 1'b0, "R10 no result after reset", 32'(res_valid), 32'd0);
        check(mem_req === 1'b0, "R9 no read after reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            lat = i % 3;
            run_vec(VECS[i], i);
        end

        // R3 first read address for root index 5 in user tree is 0x14
        lat = 4;
        @(negedge clk);
        req_valid = 1'b1; req_vpage = {7'd5, 7'd0, 6'd0}; req_super = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req === 1'b1 && mem_addr === 32'h014, "R3 root entry address", mem_addr, 32'h014);
        wait_result();
        res_ack = 1'b1; @(negedge clk); res_ack = 1'b0;

        // R1 R10: request held high during a walk is not taken; result held without ack
        lat = 2;
        @(negedge clk);
        req_valid = 1'b1; req_vpage = {7'd1, 7'd0, 6'd1}; req_super = 1'b0; req_ifetch = 1'b0;
        @(negedge clk);
        req_vpage = {7'd2, 7'd0, 6'd0};
        check(req_ready === 1'b0, "R1 busy during walk", 32'(req_ready), 32'd0);
        wait_result();
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(res_valid === 1'b1 && res_frame === 20'h0ABCD, "R10 result held until ack",
              32'(res_frame), 32'h0ABCD);
        check(res_vpage === {7'd1, 7'd0, 6'd1}, "R1 second request ignored while busy",
              32'(res_vpage), 32'({7'd1, 7'd0, 6'd1}));
        res_ack = 1'b1; @(negedge clk); res_ack = 1'b0;
        check(req_ready === 1'b1, "R10 idle after ack", 32'(req_ready), 32'd1);

        // R2 root pointer low bits ignored: urp = 0x3 selects the table at 0x000
        urp = 32'h3;
        run_vec(VECS[0], 100);
        urp = 32'h0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule